// File: doc/BRIEF.md
# SPI Slave Transceiver with Stall Watchdog

This block is the slave end of an SPI link (clock idle low, data sampled on the rising SCK edge, MSB first). The serial inputs SCK, SS and MOSI are oversampled in the system clock domain. MISO is driven from a transmit shift register. Received characters go into a single receive holding register, and a full flag marks unread data. Local logic reads and writes through a small register port.

The block reports two error conditions, each held in a sticky status bit. An overrun is a character that completes while the holding register is still full. An abort is a transaction cut short, either because SS is released in the middle of a character or because an optional watchdog finds no SCK transition for too long while SS is asserted. After a watchdog abort the block ignores SCK until SS is released. The next SS assertion then starts a new character from bit zero.

The controller has three states:
- `ST_IDLE`: SS released.
- `ST_SHIFT`: SS asserted, bits moving.
- `ST_HALT`: aborted by the watchdog, waiting for SS release.

The transitions are:
- `ST_IDLE`→`ST_SHIFT` on SS assertion.
- `ST_SHIFT`→`ST_IDLE` on SS release.
- `ST_SHIFT`→`ST_HALT` on watchdog timeout.
- `ST_HALT`→`ST_IDLE` on SS release.

The register map is:

| Address | Read | Write |
|---|---|---|
| 0 | received character, and clears the full flag | character to transmit |
| 1 | status: bit0 full, bit1 overrun, bit2 abort | 1 clears bit1 or bit2 |
| 2 | control: bit0 watchdog enable | control |
| 3 | watchdog reload value | watchdog reload value |

Top module: `spi_slave_wd`

## Requirements
- R1: After reset, status reads 0, control reads 0, the reload value reads all ones and MISO is 0.
- R2: While SS is asserted, eight rising SCK edges shift MOSI in MSB first. When the character completes on an empty register, it is stored at address 0 and status bit0 sets.
- R3: A read of address 0 returns the stored character and clears status bit0.
- R4: A character that completes while status bit0 is set sets status bit1, and the stored character is kept.
- R5: After an overrun, every further character is discarded until address 0 is read. The next character after that read is stored.
- R6: Releasing SS with a partial character sets status bit2 and resets the bit count. The next SS assertion receives a complete new character.
- R7: Releasing SS on a character boundary leaves status bit2 clear.
- R8: Writing 1 to status bit1 or bit2 clears it. Writing 0 leaves it set.
- R9: With control bit0 set, a timeout sets status bit2. A timeout is more than the reload value of cycles with SS asserted and no SCK transition. After a timeout, SCK edges are ignored until SS is released.
- R10: With control bit0 clear, no SCK stall causes an abort, and a stalled character still completes correctly.
- R11: Every SCK transition reloads the watchdog, so gaps shorter than the reload value never abort.
- R12: MISO presents the transmit character MSB first. The first bit is valid from SS assertion, and later bits follow each falling SCK edge. The character is loaded at SS assertion and again at each character end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| sck_i | input | 1 | serial clock from master |
| ss_n_i | input | 1 | slave select, active low |
| mosi_i | input | 1 | serial data from master |
| miso_o | output | 1 | serial data to master |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe (side effect at address 0) |
| reg_addr_i | input | 2 | register address |
| reg_wdata_i | input | DATA_W | register write data |
| reg_rdata_o | output | DATA_W | register read data, combinational from address |

## Verification
The hardest state to reach from the ports is `ST_HALT` with SS still asserted.

Reaching it needs three steps. First, the watchdog must be enabled with a short reload value. Second, the bench starts a character and then stops SCK partway through for longer than that reload value. Third, the bench toggles SCK while SS is still asserted, to show those edges are ignored.

The bench then releases SS and sends a full character. That character arrives intact, which proves the bit count was reset. A stall of the same length with the watchdog disabled must instead complete the character and report no abort.

A similar chain of three characters without a read, then a read, then a fourth character, shows that the oldest data is kept and that reception resumes after the read.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HALT  = 2'd2
    } spis_state_t;

    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_STAT   = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_RELOAD = 2'd3;

    localparam int STAT_FULL = 0;
    localparam int STAT_OVR  = 1;
    localparam int STAT_ABT  = 2;
    localparam int CTRL_WDEN = 0;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q, stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    stab_q <= RST_VAL[g];
                end else begin
                    meta_q <= d_i[g];
                    stab_q <= meta_q;
                end
            end
            assign q_o[g] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/spis_wdt.sv
module spis_wdt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ss_act,
    input  logic             sck_edge,
    input  logic [CNT_W-1:0] reload,
    output logic             timeout
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (!ss_act || !enable || sck_edge) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign timeout = enable && ss_act && (cnt_q == '0);
endmodule

// File: rtl/spis_core.sv
module spis_core
    import spis_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              ss_act,
    input  logic              mosi_s,
    input  logic              timeout,
    input  logic [DATA_W-1:0] tx_data,
    output logic              char_done,
    output logic [DATA_W-1:0] rx_char,
    output logic              abort_evt,
    output logic              sck_edge,
    output logic              miso,
    output spis_state_t       state_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    spis_state_t       state_q, state_d;
    logic              sck_q;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_sh_q, tx_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end
    assign sck_rise = sck_s && !sck_q;
    assign sck_fall = !sck_s && sck_q;
    assign sck_edge = sck_rise || sck_fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ss_act) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!ss_act)      state_d = ST_IDLE;
                else if (timeout) state_d = ST_HALT;
            end
            ST_HALT:  if (!ss_act) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q <= '0;
                    if (ss_act) tx_sh_q <= tx_data;
                end
                ST_SHIFT: begin
                    if (!ss_act || timeout) begin
                        bit_cnt_q <= '0;
                    end else if (sck_rise) begin
                        rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_s};
                        if (bit_cnt_q == LAST) begin
                            bit_cnt_q <= '0;
                            tx_sh_q   <= tx_data;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end else if (sck_fall && bit_cnt_q != '0) begin
                        tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                    end
                end
                ST_HALT: bit_cnt_q <= '0;
                default: bit_cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        char_done = (state_q == ST_SHIFT) && ss_act && !timeout &&
                    sck_rise && (bit_cnt_q == LAST);
        rx_char   = {rx_sh_q[DATA_W-2:0], mosi_s};
        abort_evt = (state_q == ST_SHIFT) &&
                    ((!ss_act && bit_cnt_q != '0) || (ss_act && timeout));
        miso      = tx_sh_q[DATA_W-1];
        state_o   = state_q;
        bit_cnt_o = bit_cnt_q;
    end
endmodule

// File: rtl/spis_regs.sv
module spis_regs
    import spis_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              char_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              abort_evt,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] reload,
    output logic              wd_en,
    output logic              rx_full,
    output logic              ovr,
    output logic              abt,
    output logic              rd_clr
);
    logic wr_data, wr_stat, wr_ctrl, wr_rel;

    assign wr_data = reg_wr && reg_addr == ADDR_DATA;
    assign wr_stat = reg_wr && reg_addr == ADDR_STAT;
    assign wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
    assign wr_rel  = reg_wr && reg_addr == ADDR_RELOAD;
    assign rd_clr  = reg_rd && reg_addr == ADDR_DATA;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_data <= '0;
            rx_data <= '0;
            reload  <= '1;
            wd_en   <= 1'b0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
            abt     <= 1'b0;
        end else begin
            if (wr_data) tx_data <= reg_wdata;
            if (wr_ctrl) wd_en   <= reg_wdata[CTRL_WDEN];
            if (wr_rel)  reload  <= reg_wdata;

            if (char_done && !rx_full) begin
                rx_data <= rx_char;
                rx_full <= 1'b1;
            end else if (rd_clr) begin
                rx_full <= 1'b0;
            end

            if (char_done && rx_full)                 ovr <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_OVR])  ovr <= 1'b0;

            if (abort_evt)                            abt <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_ABT])  abt <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DATA:   reg_rdata = rx_data;
            ADDR_STAT: begin
                reg_rdata[STAT_FULL] = rx_full;
                reg_rdata[STAT_OVR]  = ovr;
                reg_rdata[STAT_ABT]  = abt;
            end
            ADDR_CTRL:   reg_rdata[CTRL_WDEN] = wd_en;
            ADDR_RELOAD: reg_rdata = reload;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_slave_wd.sv
module spi_slave_wd
    import spis_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    logic [2:0]        sync_q;
    logic              sck_s, ss_act, mosi_s;
    logic              timeout, wd_en, sck_edge;
    logic              char_done, abort_evt, rd_clr;
    logic              rx_full, ovr, abt;
    logic [DATA_W-1:0] rx_char, rx_data, tx_data, reload;
    spis_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;

    spis_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sck_i, ss_n_i, mosi_i}),
        .q_o(sync_q)
    );
    assign sck_s  = sync_q[2];
    assign ss_act = !sync_q[1];
    assign mosi_s = sync_q[0];

    spis_wdt #(.CNT_W(DATA_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .enable(wd_en), .ss_act(ss_act),
        .sck_edge(sck_edge), .reload(reload), .timeout(timeout)
    );

    spis_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .ss_act(ss_act),
        .mosi_s(mosi_s), .timeout(timeout), .tx_data(tx_data),
        .char_done(char_done), .rx_char(rx_char), .abort_evt(abort_evt),
        .sck_edge(sck_edge), .miso(miso_o), .state_o(state),
        .bit_cnt_o(bit_cnt)
    );

    spis_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr_i), .reg_rd(reg_rd_i),
        .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i),
        .char_done(char_done), .rx_char(rx_char), .abort_evt(abort_evt),
        .reg_rdata(reg_rdata_o), .tx_data(tx_data), .rx_data(rx_data),
        .reload(reload), .wd_en(wd_en), .rx_full(rx_full), .ovr(ovr),
        .abt(abt), .rd_clr(rd_clr)
    );
endmodule

// File: rtl/spis_checker.sv
module spis_checker
    import spis_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input spis_state_t       state,
    input logic              ss_act,
    input logic              timeout,
    input logic              wd_en,
    input logic              char_done,
    input logic              rd_clr,
    input logic              rx_full,
    input logic              ovr,
    input logic              abt,
    input logic [DATA_W-1:0] rx_char,
    input logic [DATA_W-1:0] rx_data,
    input logic [CNT_W-1:0]  bit_cnt
);
    p_store_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !rx_full) |=> (rx_full && rx_data == $past(rx_char)));

    p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_full) |=> (ovr && $stable(rx_data)));

    p_abort_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !ss_act && bit_cnt != '0) |=> (abt && bit_cnt == '0));

    p_clean_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !ss_act && bit_cnt == '0 && !abt) |=> !abt);

    p_timeout_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && ss_act && timeout) |=> (abt && state == ST_HALT));

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && ss_act) |=> (state == ST_HALT && !char_done));

    p_wd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |-> !timeout);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !char_done) |=> !rx_full);
endmodule

bind spi_slave_wd spis_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .ss_act(ss_act),
    .timeout(timeout), .wd_en(wd_en), .char_done(char_done),
    .rd_clr(rd_clr), .rx_full(rx_full), .ovr(ovr), .abt(abt),
    .rx_char(rx_char), .rx_data(rx_data), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_slave_wd.sv
`timescale 1ns/1ps
module tb_spi_slave_wd;
    localparam int H = 8;
    localparam logic [15:0] VEC [0:3] = '{16'h3CA5, 16'hF00F, 16'h8101, 16'h5AC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    spi_slave_wd dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic pop, output logic [7:0] d);
        @(negedge clk); addr = a; rd = pop;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic ss_on();
        @(negedge clk); ss_n = 1'b0; wait_clk(H);
    endtask

    task automatic ss_off();
        @(negedge clk); ss_n = 1'b1; wait_clk(H);
    endtask

    // n bits from mo, MSB first, collecting MISO before each rising edge
    task automatic spi_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
        mi = '0;
        for (int i = 0; i < n; i++) begin
            mosi = mo[7-i];
            wait_clk(H);
            mi[7-i] = miso;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
        wait_clk(H);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        logic [7:0] d, mi;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        reg_read(2'd1, 1'b0, d); check(d == 8'h00, "R1 status", d, 8'h00);
        reg_read(2'd2, 1'b0, d); check(d == 8'h00, "R1 control", d, 8'h00);
        reg_read(2'd3, 1'b0, d); check(d == 8'hFF, "R1 reload", d, 8'hFF);
        check(miso == 1'b0, "R1 miso", {7'd0, miso}, 8'h00);

        // Table walk: R2 R3 R7 R12
        for (int v = 0; v < 4; v++) begin
            reg_write(2'd0, VEC[v][15:8]);
            ss_on();
            spi_bits(VEC[v][7:0], 8, mi);
            ss_off();
            check(mi == VEC[v][15:8], "R12 miso char", mi, VEC[v][15:8]);
            reg_read(2'd1, 1'b0, d); check(d == 8'h01, "R2 full set, R7 no abort", d, 8'h01);
            reg_read(2'd0, 1'b1, d); check(d == VEC[v][7:0], "R2 R3 data", d, VEC[v][7:0]);
            reg_read(2'd1, 1'b0, d); check(d == 8'h00, "R3 full cleared", d, 8'h00);
        end

        // R12: two characters in one selection, reload at character end
        reg_write(2'd0, 8'hB4);
        ss_on();
        spi_bits(8'h11, 8, mi); check(mi == 8'hB4, "R12 first", mi, 8'hB4);
        spi_bits(8'h22, 8, mi); check(mi == 8'hB4, "R12 second", mi, 8'hB4);
        ss_off();
        reg_read(2'd0, 1'b1, d); check(d == 8'h11, "R4 kept first", d, 8'h11);
        reg_read(2'd1, 1'b0, d); check(d == 8'h02, "R4 overrun flag", d, 8'h02);
        reg_write(2'd1, 8'h02);

        // R4 R5 overrun chain
        ss_on();
        spi_bits(8'hA1, 8, mi);
        spi_bits(8'hB2, 8, mi);
        spi_bits(8'hC3, 8, mi);
        ss_off();
        reg_read(2'd1, 1'b0, d); check(d == 8'h03, "R4 status", d, 8'h03);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, 1'b0, d); check(d == 8'h03, "R8 write 0 keeps", d, 8'h03);
        reg_read(2'd0, 1'b1, d); check(d == 8'hA1, "R5 oldest kept", d, 8'hA1);
        reg_write(2'd1, 8'h02);
        reg_read(2'd1, 1'b0, d); check(d == 8'h00, "R8 overrun cleared", d, 8'h00);
        ss_on(); spi_bits(8'hD4, 8, mi); ss_off();
        reg_read(2'd0, 1'b1, d); check(d == 8'hD4, "R5 resumes", d, 8'hD4);

        // R6 partial abort
        ss_on(); spi_bits(8'hFF, 3, mi); ss_off();
        reg_read(2'd1, 1'b0, d); check(d == 8'h04, "R6 abort", d, 8'h04);
        reg_write(2'd1, 8'h04);
        reg_read(2'd1, 1'b0, d); check(d == 8'h00, "R8 abort cleared", d, 8'h00);
        ss_on(); spi_bits(8'h5A, 8, mi); ss_off();
        reg_read(2'd0, 1'b1, d); check(d == 8'h5A, "R6 fresh char", d, 8'h5A);

        // R11 watchdog on, normal gaps
        reg_write(2'd3, 8'd20);
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, 1'b0, d); check(d == 8'h01, "R9 control", d, 8'h01);
        ss_on(); spi_bits(8'h77, 8, mi); ss_off();
        reg_read(2'd1, 1'b0, d); check(d == 8'h01, "R11 no abort", d, 8'h01);
        reg_read(2'd0, 1'b1, d); check(d == 8'h77, "R11 data", d, 8'h77);

        // R9 stall then ignored edges
        ss_on();
        spi_bits(8'hFF, 3, mi);
        wait_clk(60);
        reg_read(2'd1, 1'b0, d); check(d == 8'h04, "R9 timeout abort", d, 8'h04);
        spi_bits(8'hFF, 8, mi);
        ss_off();
        reg_read(2'd1, 1'b0, d); check(d == 8'h04, "R9 edges ignored", d, 8'h04);
        reg_write(2'd1, 8'h04);
        ss_on(); spi_bits(8'h96, 8, mi); ss_off();
        reg_read(2'd0, 1'b1, d); check(d == 8'h96, "R9 fresh after halt", d, 8'h96);

        // R10 watchdog off, long stall
        reg_write(2'd2, 8'h00);
        ss_on();
        spi_bits(8'h6B, 3, mi);
        wait_clk(100);
        spi_bits(8'h6B << 3, 5, mi);
        ss_off();
        reg_read(2'd1, 1'b0, d); check(d == 8'h01, "R10 no abort", d, 8'h01);
        reg_read(2'd0, 1'b1, d); check(d == 8'h6B, "R10 data", d, 8'h6B);

        report();
        $finish;
    end
endmodule